// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps a wall-clock calendar (seconds, minutes, hours, day of month, month and a two-digit year meaning 2000 to 2099) in packed BCD. The count is driven by a single-cycle tick enable at 32768 Hz. A prescaler divides the tick down to one calendar step per second. The calendar handles the length of each month and a leap February in every year that divides by four.

Software uses a byte-wide register port, with a write strobe and a combinational read path. Through it software sets the time, loads a six-field alarm, starts or stops the count and enables two interrupt outputs. A status flag warns that a calendar step is imminent. The alarm needs an exact match on all six fields and has no wildcard fields. Event flags in the status register record each seconds, minutes, hours and day step and each alarm hit. Software clears a flag by writing a 1 to its bit.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00. Every alarm field, the control register, the status register, the interrupt-enable register and both interrupt outputs read zero.
- R2: The register map is fixed. The time fields sit at byte addresses 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14, in the order seconds, minutes, hours, day, month, year. The alarm fields use the same order at 0x20 to 0x34. Control is at 0x40, status at 0x44 and interrupt enable at 0x48. Any other address reads 0x00, and a write to an alarm field reads back unchanged.
- R3: Control bit 0 set lets the calendar advance by one second for every TICKS_PER_SEC tick enables. With the bit clear, the time holds.
- R4: Seconds and minutes count 00 to 59 in BCD and carry on 59. Hours count 00 to 23 and carry into the day.
- R5: The day wraps to 01 after the last day of the current month. That is day 29 for February when the binary year divides by 4, day 28 for other Februaries, day 30 for April, June, September and November, and day 31 otherwise. Month 12 wraps to 01 with a carry into the year, and year 99 wraps to 00.
- R6: A write to a time field is visible on the next cycle and restarts the prescaler. The next step then needs a full TICKS_PER_SEC ticks, and any step due in the same cycle as the write is dropped.
- R7: Status bit 0 (busy) is 1 only during the tick period just before a step. It rises after TICKS_PER_SEC-1 counted ticks and falls with the step.
- R8: Status bit 1 copies control bit 0 as sampled at the most recent tick enable.
- R9: Status bits 2, 3, 4 and 5 are set by a seconds, minutes, hours and day step respectively. Writing 1 to such a bit clears it. Writing 0 leaves it as it is. A set in the same cycle wins over a clear.
- R10: Status bit 6 is set by a step whose new time equals all six alarm fields. A difference in any single field prevents it. Writing 1 to the bit clears it.
- R11: irq_timer is interrupt-enable bit 2 AND status bit 2. irq_alarm is interrupt-enable bit 3 AND status bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | One-cycle pulse per 32 kHz oscillator period |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_timer | output | 1 | Per-second interrupt request |
| irq_alarm | output | 1 | Alarm interrupt request |

## Verification
The embedded assertions guard several properties on every cycle. The prescaler count stays in range and freezes between ticks. The run copy moves only on a tick. The time changes only through a step or a write. Every rise of the alarm or seconds flag traces back to a step, and a valid month stays valid across a step. Only the bench scenarios can show the calendar arithmetic itself. This covers the carry chain across an hour of steps, every month end in leap and common years, the exact tick on which busy rises, the prescaler restart and the refusal of each single-field alarm mismatch.

// File: rtl/rtc_cal_pkg.sv
// Shared definitions for the BCD calendar: field indices, register
// addresses, status bit positions and BCD helper functions.
// Assumes every stored field holds valid packed BCD.
package rtc_cal_pkg;

    localparam int NFIELD = 6;
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DAY  = 3;
    localparam int F_MON  = 4;
    localparam int F_YEAR = 5;

    // One byte per field, index order matches the address order.
    typedef logic [NFIELD-1:0][7:0] cal_t;

    localparam cal_t CAL_RESET = {8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    localparam logic [2:0] PAGE_TIME  = 3'b000;
    localparam logic [2:0] PAGE_ALARM = 3'b001;
    localparam logic [7:0] ADDR_CTRL  = 8'h40;
    localparam logic [7:0] ADDR_STAT  = 8'h44;
    localparam logic [7:0] ADDR_IEN   = 8'h48;

    localparam int ST_BUSY = 0;
    localparam int ST_RUN  = 1;
    localparam int ST_SEC  = 2;
    localparam int ST_MIN  = 3;
    localparam int ST_HOUR = 4;
    localparam int ST_DAY  = 5;
    localparam int ST_ALM  = 6;
    localparam int IE_TMR  = 2;
    localparam int IE_ALM  = 3;

    // Add one to a two-digit BCD value (caller handles the wrap).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Leap test: (10*t + o) mod 4 equals (2*t + o) mod 4.
    function automatic logic is_leap(input logic [7:0] yr);
        logic [4:0] s;
        s = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};
        return (s[1:0] == 2'b00);
    endfunction

    // Last valid day (BCD) of a BCD month in a BCD year.
    function automatic logic [7:0] month_last_day(input logic [7:0] mon,
                                                  input logic [7:0] yr);
        case (mon)
            8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    // True when a BCD month lies in 01..12.
    function automatic logic month_ok(input logic [7:0] mon);
        return ((mon >= 8'h01) && (mon <= 8'h09)) ||
               ((mon >= 8'h10) && (mon <= 8'h12));
    endfunction

endpackage

// File: rtl/rtc_tick_prescaler.sv
// Divides the 32 kHz tick enable down to one calendar step per second.
// It holds the synchronised run flag, raises busy for the final tick
// period before a step and restarts on request. Assumes TICKS_PER_SEC >= 1.
module rtc_tick_prescaler #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic run_req,
    input  logic restart,
    output logic run_q,
    output logic busy,
    output logic sec_pulse
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt;

    // Sample the software run bit into the tick domain.
    always_ff @(posedge clk) begin
        if (!rst_n)       run_q <= 1'b0;
        else if (tick_en) run_q <= run_req;
    end

    // Count ticks while running; a restart returns to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (restart)          cnt <= '0;
        else if (tick_en && run_q) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    // Busy marks the last tick period; the step happens at its end.
    always_comb begin
        busy      = run_q && (cnt == LAST);
        sec_pulse = tick_en && busy && !restart;
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    p_cnt_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !restart) |=> $stable(cnt));
    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
    p_run_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(run_q));
    p_step_wraps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sec_pulse |=> (cnt == '0));

endmodule

// File: rtl/rtc_cal_next.sv
// Combinational successor of a BCD calendar value, one second later.
// It also reports which carries occurred. Assumes valid BCD fields.
module rtc_cal_next
    import rtc_cal_pkg::*;
(
    input  cal_t cur,
    output cal_t nxt,
    output logic min_step,
    output logic hour_step,
    output logic day_step
);
    logic sec_wrap, min_wrap, hr_wrap, day_wrap, mon_wrap;

    // Detect per-field wrap conditions.
    always_comb begin
        sec_wrap = (cur[F_SEC]  == 8'h59);
        min_wrap = (cur[F_MIN]  == 8'h59);
        hr_wrap  = (cur[F_HOUR] == 8'h23);
        day_wrap = (cur[F_DAY]  == month_last_day(cur[F_MON], cur[F_YEAR]));
        mon_wrap = (cur[F_MON]  == 8'h12);
    end

    // Ripple the carry from seconds up to the year.
    always_comb begin
        nxt       = cur;
        min_step  = sec_wrap;
        hour_step = sec_wrap && min_wrap;
        day_step  = hour_step && hr_wrap;
        nxt[F_SEC] = sec_wrap ? 8'h00 : bcd_inc(cur[F_SEC]);
        if (min_step)
            nxt[F_MIN] = min_wrap ? 8'h00 : bcd_inc(cur[F_MIN]);
        if (hour_step)
            nxt[F_HOUR] = hr_wrap ? 8'h00 : bcd_inc(cur[F_HOUR]);
        if (day_step)
            nxt[F_DAY] = day_wrap ? 8'h01 : bcd_inc(cur[F_DAY]);
        if (day_step && day_wrap)
            nxt[F_MON] = mon_wrap ? 8'h01 : bcd_inc(cur[F_MON]);
        if (day_step && day_wrap && mon_wrap)
            nxt[F_YEAR] = (cur[F_YEAR] == 8'h99) ? 8'h00 : bcd_inc(cur[F_YEAR]);
    end

endmodule

// File: rtl/rtc_alarm_cmp.sv
// Full-match comparator between a candidate time and the alarm fields.
// Every field must be equal; there is no wildcard value.
module rtc_alarm_cmp
    import rtc_cal_pkg::*;
(
    input  cal_t cand,
    input  cal_t alm,
    output logic match
);
    logic [NFIELD-1:0] eq;

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        // Per-field equality.
        assign eq[g] = (cand[g] == alm[g]);
    end

    // All fields must agree.
    assign match = &eq;

endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top level: byte register bank, calendar state, event flags and
// interrupt outputs around the prescaler, successor and alarm compare.
// Assumes software writes valid BCD to time and alarm fields.
module rtc_bcd_calendar
    import rtc_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq_timer,
    output logic       irq_alarm
);
    cal_t       time_q, alarm_q, time_nxt;
    logic       ctrl_run, ien_tmr, ien_alm;
    logic       ev_sec, ev_min, ev_hour, ev_day, ev_alm;
    logic       run_sync, busy, upd, alm_match;
    logic       min_step, hour_step, day_step;
    logic [2:0] fidx;
    logic       fld_ok, time_sel, alm_sel, time_wr, alm_wr, st_wr;
    logic [7:0] rd_time, rd_alm;

    // Address decode for the field pages and single registers.
    always_comb begin
        fidx     = reg_addr[4:2];
        fld_ok   = (reg_addr[1:0] == 2'b00) && (fidx < 3'(NFIELD));
        time_sel = fld_ok && (reg_addr[7:5] == PAGE_TIME);
        alm_sel  = fld_ok && (reg_addr[7:5] == PAGE_ALARM);
        time_wr  = reg_wr && time_sel;
        alm_wr   = reg_wr && alm_sel;
        st_wr    = reg_wr && (reg_addr == ADDR_STAT);
    end

    rtc_tick_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .run_req   (ctrl_run),
        .restart   (time_wr),
        .run_q     (run_sync),
        .busy      (busy),
        .sec_pulse (upd)
    );

    rtc_cal_next u_next (
        .cur       (time_q),
        .nxt       (time_nxt),
        .min_step  (min_step),
        .hour_step (hour_step),
        .day_step  (day_step)
    );

    rtc_alarm_cmp u_match (
        .cand  (time_nxt),
        .alm   (alarm_q),
        .match (alm_match)
    );

    // Calendar state: software write has priority over the step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= CAL_RESET;
        end else if (time_wr) begin
            for (int i = 0; i < NFIELD; i++)
                if (int'(fidx) == i) time_q[i] <= reg_wdata;
        end else if (upd) begin
            time_q <= time_nxt;
        end
    end

    // Alarm field storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
        end else if (alm_wr) begin
            for (int i = 0; i < NFIELD; i++)
                if (int'(fidx) == i) alarm_q[i] <= reg_wdata;
        end
    end

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_run <= 1'b0;
            ien_tmr  <= 1'b0;
            ien_alm  <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CTRL) ctrl_run <= reg_wdata[0];
            if (reg_addr == ADDR_IEN) begin
                ien_tmr <= reg_wdata[IE_TMR];
                ien_alm <= reg_wdata[IE_ALM];
            end
        end
    end

    // Sticky event flags: set by a step, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_sec  <= 1'b0;
            ev_min  <= 1'b0;
            ev_hour <= 1'b0;
            ev_day  <= 1'b0;
            ev_alm  <= 1'b0;
        end else begin
            if (upd)                           ev_sec  <= 1'b1;
            else if (st_wr && reg_wdata[ST_SEC])  ev_sec  <= 1'b0;
            if (upd && min_step)               ev_min  <= 1'b1;
            else if (st_wr && reg_wdata[ST_MIN])  ev_min  <= 1'b0;
            if (upd && hour_step)              ev_hour <= 1'b1;
            else if (st_wr && reg_wdata[ST_HOUR]) ev_hour <= 1'b0;
            if (upd && day_step)               ev_day  <= 1'b1;
            else if (st_wr && reg_wdata[ST_DAY])  ev_day  <= 1'b0;
            if (upd && alm_match)              ev_alm  <= 1'b1;
            else if (st_wr && reg_wdata[ST_ALM])  ev_alm  <= 1'b0;
        end
    end

    // Field selection for reads.
    always_comb begin
        rd_time = 8'h00;
        rd_alm  = 8'h00;
        for (int i = 0; i < NFIELD; i++) begin
            if (int'(fidx) == i) begin
                rd_time = time_q[i];
                rd_alm  = alarm_q[i];
            end
        end
    end

    // Read data multiplexer.
    always_comb begin
        if (time_sel)                    reg_rdata = rd_time;
        else if (alm_sel)                reg_rdata = rd_alm;
        else if (reg_addr == ADDR_CTRL)  reg_rdata = {7'd0, ctrl_run};
        else if (reg_addr == ADDR_STAT)  reg_rdata = {1'b0, ev_alm, ev_day, ev_hour,
                                                     ev_min, ev_sec, run_sync, busy};
        else if (reg_addr == ADDR_IEN)   reg_rdata = {4'd0, ien_alm, ien_tmr, 2'd0};
        else                             reg_rdata = 8'h00;
    end

    // Interrupt requests.
    assign irq_timer = ien_tmr && ev_sec;
    assign irq_alarm = ien_alm && ev_alm;

    p_time_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && !time_wr) |=> $stable(time_q));
    p_busy_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run_sync);
    p_alarm_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_alm) |-> $past(upd && alm_match));
    p_sec_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_sec) |-> $past(upd));
    p_w1c_sec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata[ST_SEC] && !upd) |=> !ev_sec);
    p_month_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && month_ok(time_q[F_MON])) |=> month_ok(time_q[F_MON]));

endmodule

// File: tb/sim_rtc_bcd_calendar.sv
module sim_rtc_bcd_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int T = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_timer, irq_alarm;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int ms, mm, mh, md, mmo, my;

    rtc_bcd_calendar #(.TICKS_PER_SEC(T)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_timer(irq_timer), .irq_alarm(irq_alarm)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] bcd(input int x);
        return 8'(((x / 10) * 16) + (x % 10));
    endfunction

    function automatic int mlen(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic logic [47:0] exp_time();
        return {bcd(my), bcd(mmo), bcd(md), bcd(mh), bcd(mm), bcd(ms)};
    endfunction

    task automatic adv();
        ms++;
        if (ms == 60) begin
            ms = 0; mm++;
            if (mm == 60) begin
                mm = 0; mh++;
                if (mh == 24) begin
                    mh = 0; md++;
                    if (md > mlen(mmo, my)) begin
                        md = 1; mmo++;
                        if (mmo == 13) begin mmo = 1; my = (my + 1) % 100; end
                    end
                end
            end
        end
    endtask

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic read_block(input logic [7:0] base, output logic [47:0] t);
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(8'(base + i * 4), v);
            t[i*8 +: 8] = v;
        end
    endtask

    task automatic set_time(input int y, input int mo, input int d,
                            input int h, input int m, input int s);
        wr(8'h14, bcd(y)); wr(8'h10, bcd(mo)); wr(8'h0C, bcd(d));
        wr(8'h08, bcd(h)); wr(8'h04, bcd(m)); wr(8'h00, bcd(s));
        my = y; mmo = mo; md = d; mh = h; mm = m; ms = s;
    endtask

    task automatic set_alarm(input logic [47:0] a);
        for (int i = 0; i < 6; i++) wr(8'(8'h20 + i * 4), a[i*8 +: 8]);
    endtask

    task automatic one_sec();
        repeat (T) tick();
        adv();
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0]  v;
        logic [47:0] t;
        logic [47:0] a;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_block(8'h00, t); chk("R1 time", t, 48'h00_01_01_00_00_00);
        read_block(8'h20, t); chk("R1 alarm", t, 48'h0);
        rd(8'h40, v); chk("R1 ctrl", 48'(v), 48'h0);
        rd(8'h44, v); chk("R1 status", 48'(v), 48'h0);
        rd(8'h48, v); chk("R1 ien", 48'(v), 48'h0);
        chk("R1 irqs", {46'd0, irq_timer, irq_alarm}, 48'h0);

        // R2 alarm readback and unmapped address
        set_alarm(48'h12_34_56_78_9A_BC);
        read_block(8'h20, t); chk("R2 alarm readback", t, 48'h12_34_56_78_9A_BC);
        rd(8'h3C, v); chk("R2 unmapped", 48'(v), 48'h0);
        rd(8'h4C, v); chk("R2 unmapped hi", 48'(v), 48'h0);

        // R8 run sync
        wr(8'h40, 8'h01);
        rd(8'h44, v); chk("R8 run before tick", 48'(v[1]), 48'h0);
        tick();
        rd(8'h44, v); chk("R8 run after tick", 48'(v[1]), 48'h1);

        // R3 / R7 step timing and busy window
        set_time(23, 6, 15, 12, 34, 56);
        for (int k = 1; k < T; k++) begin
            tick();
            rd(8'h00, v); chk("R3 no early step", 48'(v), 48'(bcd(56)));
            rd(8'h44, v); chk("R7 busy window", 48'(v[0]), 48'(k == T - 1));
        end
        tick(); adv();
        rd(8'h00, v); chk("R3 step", 48'(v), 48'(bcd(57)));
        rd(8'h44, v); chk("R7 busy falls", 48'(v[0]), 48'h0);
        chk("R9 sec event only", 48'(v[5:2]), 48'h1);

        // R9 write-zero keeps, write-one clears
        wr(8'h44, 8'h00);
        rd(8'h44, v); chk("R9 write0 keeps", 48'(v[2]), 48'h1);
        wr(8'h44, 8'h04);
        rd(8'h44, v); chk("R9 write1 clears", 48'(v[2]), 48'h0);

        // R3 stopped clock holds
        wr(8'h40, 8'h00); tick();
        rd(8'h44, v); chk("R8 run cleared", 48'(v[1]), 48'h0);
        repeat (2 * T) tick();
        read_block(8'h00, t); chk("R3 stopped holds", t, exp_time());
        wr(8'h40, 8'h01); tick();

        // R6 write restarts prescaler
        set_time(23, 6, 15, 10, 20, 30);
        repeat (T - 2) tick();
        wr(8'h00, bcd(45)); ms = 45;
        rd(8'h00, v); chk("R6 write visible", 48'(v), 48'(bcd(45)));
        repeat (T - 1) tick();
        rd(8'h00, v); chk("R6 no step after restart", 48'(v), 48'(bcd(45)));
        rd(8'h44, v); chk("R6 busy after T-1", 48'(v[0]), 48'h1);
        tick(); adv();
        rd(8'h00, v); chk("R6 step after full period", 48'(v), 48'(bcd(46)));

        // R4 hour-long sweep of the seconds/minutes/hours chain
        set_time(23, 6, 15, 0, 0, 0);
        for (int n = 0; n < 3661; n++) begin
            logic [7:0] s, m, h;
            one_sec();
            rd(8'h00, s); rd(8'h04, m); rd(8'h08, h);
            chk("R4 hms chain", {24'd0, h, m, s}, {24'd0, bcd(mh), bcd(mm), bcd(ms)});
        end

        // R5 / R9 month ends in leap and common years
        for (int yi = 0; yi < 4; yi++) begin
            for (int mo = 1; mo <= 12; mo++) begin
                int y;
                y = (yi == 0) ? 0 : (yi == 1) ? 1 : (yi == 2) ? 4 : 99;
                wr(8'h44, 8'h7C);
                set_time(y, mo, mlen(mo, y), 23, 59, 59);
                one_sec();
                read_block(8'h00, t); chk("R5 month end", t, exp_time());
                rd(8'h44, v); chk("R9 all step events", 48'(v[5:2]), 48'hF);
            end
        end
        for (int y = 0; y < 8; y++) begin
            set_time(y, 2, 28, 23, 59, 59);
            one_sec();
            read_block(8'h00, t); chk("R5 feb 28", t, exp_time());
        end

        // R10 single-field mismatch never fires
        set_time(57, 3, 9, 8, 7, 6);
        for (int f = 0; f < 6; f++) begin
            wr(8'h44, 8'h7C);
            adv();
            a = exp_time();
            a[f*8 +: 8] = a[f*8 +: 8] ^ 8'h01;
            set_alarm(a);
            repeat (T) tick();
            rd(8'h44, v); chk("R10 mismatch no alarm", 48'(v[6]), 48'h0);
        end

        // R10 / R11 full match
        wr(8'h48, 8'h08);
        wr(8'h44, 8'h7C);
        adv();
        set_alarm(exp_time());
        repeat (T) tick();
        rd(8'h44, v); chk("R10 full match", 48'(v[6]), 48'h1);
        chk("R11 alarm irq", 48'(irq_alarm), 48'h1);
        chk("R11 timer irq masked", 48'(irq_timer), 48'h0);
        wr(8'h48, 8'h0C);
        rd(8'h48, v); chk("R2 ien readback", 48'(v), 48'h0C);
        chk("R11 timer irq", 48'(irq_timer), 48'h1);
        wr(8'h44, 8'h40);
        rd(8'h44, v); chk("R10 alarm cleared", 48'(v[6]), 48'h0);
        chk("R11 alarm irq drops", 48'(irq_alarm), 48'h0);
        chk("R11 timer irq stays", 48'(irq_timer), 48'h1);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule